// File: doc/BRIEF.md
# UART Receive Flow Control

This block drives the active-low request-to-send line of a UART receiver and tells the local transmitter when the far end allows it to send. The receiver's FIFO reports its number of free slots. A three-bit configuration selects how the request-to-send line behaves. When flow control is off, the line stays high and the incoming clear-to-send pin is ignored. In software mode, a register bit sets the line. In automatic mode, the line is asserted only while at least two slots are free. The threshold is two, not one, so that a character the peer has already started still has a slot.

Software mode is meant for peers that keep sending for a while after the request is withdrawn. Software can deassert the request earlier than the automatic threshold would. The incoming clear-to-send pin is asynchronous, so it passes through a two-flop synchronizer. The synchronized value then becomes a start qualifier. The transmitter checks this qualifier before it begins each new character. A character already in progress is never cut short.

Top module: `uart_rx_flowctl`

## Requirements
- R1: With flow enabled and automatic mode selected, `rts_n` is 0 one clock after an edge at which `fifo_free` is 2 or more.
- R2: With flow enabled and automatic mode selected, `rts_n` is 1 one clock after an edge at which `fifo_free` is 0 or 1.
- R3: With flow enabled and automatic mode off, `rts_n` is the inverse of `cfg_sw_rts` (1 = request asserted) sampled at the previous edge.
- R4: With flow disabled, `rts_n` is 1 one clock later, whatever the values of `cfg_auto_en`, `cfg_sw_rts` and `fifo_free`.
- R5: With flow disabled, `tx_cts_ok` is 1 whatever the value of `cts_n`.
- R6: With flow enabled, `tx_cts_ok` is the inverse of `cts_n` as sampled two clock edges earlier.
- R7: During reset, `rts_n` is 1 and the synchronizer holds the deasserted value. As a result, `tx_cts_ok` equals the inverse of `cfg_flow_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_flow_en | input | 1 | Enables RTS/CTS flow control |
| cfg_auto_en | input | 1 | Selects the automatic request from FIFO room |
| cfg_sw_rts | input | 1 | Software request value, 1 = assert |
| fifo_free | input | CNT_W (4) | Free slots in the receive FIFO |
| cts_n | input | 1 | Asynchronous clear-to-send pin, active low |
| rts_n | output | 1 | Registered request-to-send pin, active low |
| tx_cts_ok | output | 1 | Transmitter may start a new character |

## Verification
Two things can change in the same clock: the free-slot count can cross the two-slot threshold while the synchronized clear-to-send value toggles. A mode bit can also change in the same cycle as either of them. The random phase provokes both cases by moving the FIFO model, the pin and the configuration bits independently on every cycle. A behavioural model in the bench keeps the pin history and the expected request. It compares both outputs on every clock, so neither path can hide an error in the other.

// File: rtl/uart_rx_flowctl.sv
module uart_rx_flowctl #(
  parameter int DEPTH    = 8,
  parameter int ROOM_MIN = 2,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_flow_en,
  input  logic             cfg_auto_en,
  input  logic             cfg_sw_rts,
  input  logic [CNT_W-1:0] fifo_free,
  input  logic             cts_n,
  output logic             rts_n,
  output logic             tx_cts_ok
);

  localparam logic [CNT_W-1:0] ROOM = CNT_W'(ROOM_MIN);

  logic cts_meta, cts_sync;
  logic rts_n_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cts_meta <= 1'b1;
      cts_sync <= 1'b1;
    end else begin
      cts_meta <= cts_n;
      cts_sync <= cts_meta;
    end

  always_comb
    if (!cfg_flow_en)     rts_n_nxt = 1'b1;
    else if (cfg_auto_en) rts_n_nxt = (fifo_free < ROOM);
    else                  rts_n_nxt = ~cfg_sw_rts;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rts_n <= 1'b1;
    else        rts_n <= rts_n_nxt;

  assign tx_cts_ok = ~cfg_flow_en | ~cts_sync;

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;

  AST_AUTO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flow_en && cfg_auto_en && fifo_free >= ROOM) |=> !rts_n); // R1
  AST_AUTO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flow_en && cfg_auto_en && fifo_free < ROOM) |=> rts_n); // R2
  AST_SW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flow_en && !cfg_auto_en) |=> (rts_n == !$past(cfg_sw_rts))); // R3
  AST_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_flow_en |=> rts_n); // R4
  AST_CTS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && cfg_flow_en) |-> (tx_cts_ok == !$past(cts_n, 2))); // R6

endmodule

// File: tb/uart_rx_flowctl_test.sv
module uart_rx_flowctl_test;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic flow = 0, auto_m = 0, sw = 0, cts = 1;
  logic [CNT_W-1:0] free;
  logic rts_n, cts_ok;
  int checks = 0, errors = 0;
  int q[$];
  logic exp_rts, h1, h2;
  logic done = 0;

  always #4 clk = ~clk;
  assign free = CNT_W'(DEPTH - q.size());

  uart_rx_flowctl #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_flow_en(flow), .cfg_auto_en(auto_m),
    .cfg_sw_rts(sw), .fifo_free(free), .cts_n(cts), .rts_n(rts_n), .tx_cts_ok(cts_ok));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      exp_rts <= 1; h1 <= 1; h2 <= 1;
    end else begin
      h1 <= cts; h2 <= h1;
      if (!flow)       exp_rts <= 1;
      else if (auto_m) exp_rts <= (DEPTH - q.size()) < 2;
      else             exp_rts <= ~sw;
    end

  task automatic check(logic got, logic exp, string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    if (!rst_n) begin
      check(rts_n, 1'b1, "R7");
      check(cts_ok, ~flow, "R7");
    end else begin
      check(rts_n, exp_rts, !flow ? "R4" : !auto_m ? "R3" : exp_rts ? "R2" : "R1");
      check(cts_ok, flow ? ~h2 : 1'b1, flow ? "R6" : "R5");
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic fifo_rand();
    if (q.size() < DEPTH && $urandom_range(1, 0) == 1) q.push_back(1);
    if (q.size() > 0 && $urandom_range(2, 0) == 0) void'(q.pop_front());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    flow = 1; @(negedge clk);
    flow = 0;
    tick(); rst_n = 1;
    // R4 R5: flow off, other inputs wander
    for (int i = 0; i < 60; i++) begin
      tick(); auto_m = $urandom; sw = $urandom; cts = $urandom; fifo_rand();
    end
    // R3: software mode
    flow = 1; auto_m = 0;
    for (int i = 0; i < 40; i++) begin
      tick(); sw = $urandom; cts = $urandom;
    end
    // R1 R2: fill one per cycle to full, then drain, crossing the boundary at free 1/2
    auto_m = 1;
    while (q.size() > 0) void'(q.pop_front());
    for (int i = 0; i < DEPTH; i++) begin tick(); q.push_back(i); end
    repeat (3) tick();
    for (int i = 0; i < DEPTH; i++) begin tick(); void'(q.pop_front()); end
    repeat (3) tick();
    // concurrent changes
    for (int i = 0; i < 3000; i++) begin
      tick();
      fifo_rand(); cts = $urandom;
      if ($urandom_range(15, 0) == 0) flow = $urandom;
      if ($urandom_range(15, 0) == 0) auto_m = $urandom;
      sw = $urandom;
    end
    tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule